// File: doc/BRIEF.md
# Three-Wire Serial Debug Port

This block lets an external debug host inspect and modify a target through three signals: a clock driven by the host, a serial input and a serial output. Each transfer moves one 17-bit word in each direction at the same time, most significant bit first. The host sends commands and operands. The port turns them into single-cycle register file writes, register file reads, and memory bus requests that are held until acknowledged. Results come back in the word that follows.

The serial clock and the serial input are brought into the system clock domain through a chain of flops. Edges are detected there, so the host clock must be several system clocks slow per phase. Bit 16 of each reply is a status flag. When a memory access is still pending at the start of a word, the port replies "busy" and ignores what the host shifts in during that word. The host keeps retrying until the flag clears.

Top module: `sdbg_port`

## Requirements
- R1: The input bit is taken on each rising edge of `dbg_sck`, and `dbg_sdo` changes only after a falling edge. Words are 17 bits long, most significant bit first. The reply for a word is presented on `dbg_sdo` before that word's first rising edge.
- R2: In a host word, bits 15:12 hold an opcode: 1 reads a register, 2 writes a register, 3 reads memory, 4 writes memory. The values 0 and 5 to 15 do nothing: they cause no register write and no memory request. Bits IDX_W-1:0 hold the register index. Bit 16 of a host word is ignored.
- R3: A register write takes two words, the command and then one data word. It produces one single-cycle `reg_wr` pulse carrying the command's index and the data word.
- R4: A register read command makes the reply of the next word {0, contents of the indexed register}.
- R5: A memory command is followed by an address word with bits 31:16 and then an address word with bits 15:0. A write then takes one data word. `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` stable, until `mem_ack`. It drops in the cycle after the acknowledge.
- R6: Once a memory read completes, the next reply is {0, read data}. Once a memory write completes, the next reply is {0, 0}.
- R7: If a memory access is outstanding when a word starts, the reply is exactly {1, 16'h0000}. The word shifted in during that transfer is discarded.
- R8: The reply is {0, 0} after a command word that produces no data, after an address word, after a data word, and after an unknown opcode.
- R9: While reset is asserted, `dbg_sdo` is 0 and neither `reg_wr` nor `mem_req` is active.
- R10: `reg_wr` and `mem_req` are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_sck | input | 1 | Serial clock from the host |
| dbg_sdi | input | 1 | Serial data from the host |
| dbg_sdo | output | 1 | Serial data to the host |
| reg_wr | output | 1 | Register file write strobe |
| reg_idx | output | IDX_W | Register index |
| reg_wdata | output | 16 | Register write data |
| reg_rdata | input | 16 | Register read data for reg_idx |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory completion, one cycle |

## Verification
The hardest case to reach is a host word that arrives while a memory access is still pending. That word must be discarded even when it holds a valid command. The bench gives the memory model a latency longer than a whole serial word. It then makes a genuine register write command the first retry word and checks afterwards that the register kept its value. Random latencies, from zero up to more than one word time, cover replies that are busy once, busy several times, and never busy.

// File: rtl/sdbg_pkg.sv
package sdbg_pkg;
  localparam int WORD_W = 17;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 32;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP    = 4'd0,
    OP_REG_RD = 4'd1,
    OP_REG_WR = 4'd2,
    OP_MEM_RD = 4'd3,
    OP_MEM_WR = 4'd4
  } op_e;

  typedef enum logic [2:0] {
    ST_CMD, ST_ADDR_HI, ST_ADDR_LO, ST_WDATA, ST_REG_FETCH, ST_MEM_WAIT
  } st_e;

  // opcode field of a host word
  function automatic logic [OP_W-1:0] cmd_op(input logic [DATA_W-1:0] w);
    return w[DATA_W-1 -: OP_W];
  endfunction

  // reply word: busy flag above data, data forced to zero when busy
  function automatic logic [WORD_W-1:0] make_reply(input logic busy,
                                                   input logic [DATA_W-1:0] d);
    return busy ? {1'b1, {DATA_W{1'b0}}} : {1'b0, d};
  endfunction
endpackage

// File: rtl/sdbg_sync.sv
module sdbg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic sdi_in,
  output logic sck_rise,
  output logic sck_fall,
  output logic sdi_s
);
  logic [STAGES-1:0] sck_q, sdi_q;
  logic              sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= '0;
      sdi_q    <= '0;
      sck_prev <= 1'b0;
    end else begin
      sck_q[0] <= sck_in;
      sdi_q[0] <= sdi_in;
      for (int i = 1; i < STAGES; i++) begin
        sck_q[i] <= sck_q[i-1];
        sdi_q[i] <= sdi_q[i-1];
      end
      sck_prev <= sck_q[STAGES-1];
    end
  end

  assign sck_rise = sck_q[STAGES-1] & ~sck_prev;
  assign sck_fall = ~sck_q[STAGES-1] & sck_prev;
  assign sdi_s    = sdi_q[STAGES-1];
endmodule

// File: rtl/sdbg_shift.sv
module sdbg_shift
  import sdbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              sdi_s,
  input  logic [WORD_W-1:0] reply,
  input  logic              busy,
  output logic              sdo,
  output logic              tx_load,
  output logic              word_take,
  output logic [DATA_W-1:0] rx_word
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] rx_q, tx_q;
  logic              done_q, disc_q;

  assign tx_load = sck_fall && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      done_q <= 1'b0;
      disc_q <= 1'b0;
    end else begin
      done_q <= sck_rise && (cnt_q == LAST);
      if (sck_rise) begin
        rx_q  <= {rx_q[WORD_W-2:0], sdi_s};
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
      if (tx_load) begin
        tx_q   <= reply;
        disc_q <= busy;
      end else if (sck_fall) begin
        tx_q <= {tx_q[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign sdo       = tx_q[WORD_W-1];
  assign word_take = done_q & ~disc_q;
  assign rx_word   = rx_q[DATA_W-1:0];
endmodule

// File: rtl/sdbg_ctrl.sv
module sdbg_ctrl
  import sdbg_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_take,
  input  logic [DATA_W-1:0] word,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              reg_wr,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [DATA_W-1:0] wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              busy,
  output logic [WORD_W-1:0] reply
);
  localparam int HALF_A = ADDR_W / 2;

  st_e               st_q;
  logic [DATA_W-1:0] resp_q, wdata_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  idx_q;
  logic              to_reg_q, we_q, req_q, wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_CMD;
      resp_q   <= '0;
      wdata_q  <= '0;
      addr_q   <= '0;
      idx_q    <= '0;
      to_reg_q <= 1'b0;
      we_q     <= 1'b0;
      req_q    <= 1'b0;
      wr_q     <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      case (st_q)
        ST_CMD: if (word_take) begin
          resp_q <= '0;
          case (cmd_op(word))
            OP_REG_RD: begin
              idx_q <= word[IDX_W-1:0];
              st_q  <= ST_REG_FETCH;
            end
            OP_REG_WR: begin
              idx_q    <= word[IDX_W-1:0];
              to_reg_q <= 1'b1;
              st_q     <= ST_WDATA;
            end
            OP_MEM_RD: begin
              we_q     <= 1'b0;
              to_reg_q <= 1'b0;
              st_q     <= ST_ADDR_HI;
            end
            OP_MEM_WR: begin
              we_q     <= 1'b1;
              to_reg_q <= 1'b0;
              st_q     <= ST_ADDR_HI;
            end
            default: st_q <= ST_CMD;
          endcase
        end
        ST_REG_FETCH: begin
          resp_q <= reg_rdata;
          st_q   <= ST_CMD;
        end
        ST_ADDR_HI: if (word_take) begin
          addr_q[ADDR_W-1:HALF_A] <= word;
          resp_q <= '0;
          st_q   <= ST_ADDR_LO;
        end
        ST_ADDR_LO: if (word_take) begin
          addr_q[HALF_A-1:0] <= word;
          resp_q <= '0;
          if (we_q) begin
            st_q <= ST_WDATA;
          end else begin
            req_q <= 1'b1;
            st_q  <= ST_MEM_WAIT;
          end
        end
        ST_WDATA: if (word_take) begin
          wdata_q <= word;
          resp_q  <= '0;
          if (to_reg_q) begin
            wr_q <= 1'b1;
            st_q <= ST_CMD;
          end else begin
            req_q <= 1'b1;
            st_q  <= ST_MEM_WAIT;
          end
        end
        ST_MEM_WAIT: if (mem_ack) begin
          req_q  <= 1'b0;
          resp_q <= we_q ? '0 : mem_rdata;
          st_q   <= ST_CMD;
        end
        default: st_q <= ST_CMD;
      endcase
    end
  end

  assign busy     = (st_q == ST_MEM_WAIT) || (st_q == ST_REG_FETCH);
  assign reply    = make_reply(busy, resp_q);
  assign reg_wr   = wr_q;
  assign reg_idx  = idx_q;
  assign wdata    = wdata_q;
  assign mem_req  = req_q;
  assign mem_we   = we_q;
  assign mem_addr = addr_q;
endmodule

// File: rtl/sdbg_port.sv
module sdbg_port
  import sdbg_pkg::*;
#(
  parameter int IDX_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_sck,
  input  logic              dbg_sdi,
  output logic              dbg_sdo,
  output logic              reg_wr,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [15:0]       reg_wdata,
  input  logic [15:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  input  logic              mem_ack
);
  logic              sck_rise, sck_fall, sdi_s;
  logic              tx_load, word_take, busy;
  logic [DATA_W-1:0] rx_word, wdata;
  logic [WORD_W-1:0] reply;

  sdbg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_in(dbg_sck), .sdi_in(dbg_sdi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi_s(sdi_s)
  );

  sdbg_shift u_shift (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sdi_s(sdi_s), .reply(reply), .busy(busy), .sdo(dbg_sdo),
    .tx_load(tx_load), .word_take(word_take), .rx_word(rx_word)
  );

  sdbg_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .word_take(word_take), .word(rx_word),
    .reg_rdata(reg_rdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .reg_wr(reg_wr), .reg_idx(reg_idx), .wdata(wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .busy(busy), .reply(reply)
  );

  assign reg_wdata = wdata;
  assign mem_wdata = wdata;
endmodule

// File: rtl/sdbg_port_chk.sv
module sdbg_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        dbg_sdo,
  input logic        reg_wr,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [15:0] mem_wdata,
  input logic        busy,
  input logic        tx_load,
  input logic        sck_fall
);
  AST_SDO_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dbg_sdo) |-> $past(sck_fall)); // R1
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr); // R3
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                            && $stable(mem_wdata)); // R5
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req); // R5
  AST_BUSY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load && busy |=> dbg_sdo); // R7
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && mem_req)); // R10
endmodule

bind sdbg_port sdbg_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_sdo(dbg_sdo), .reg_wr(reg_wr),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy),
  .tx_load(tx_load), .sck_fall(sck_fall)
);

// File: tb/sdbg_port_test.sv
module sdbg_port_test;
  localparam int HALF = 6;

  logic        clk = 1'b0, rst_n = 1'b0, dbg_sck = 1'b0, dbg_sdi = 1'b0;
  logic        dbg_sdo, reg_wr, mem_req, mem_we, mem_ack;
  logic [3:0]  reg_idx;
  logic [15:0] reg_wdata, reg_rdata, mem_wdata, mem_rdata;
  logic [31:0] mem_addr, last_addr;
  logic [15:0] rf [16];
  logic [15:0] mem_arr [16];
  logic [15:0] exp_rf [16];
  logic [15:0] exp_mem [16];
  int mem_lat = 0, wait_cnt = 0;
  int n_chk = 0, n_bad = 0, wr_pulses = 0, req_starts = 0, overlap = 0;
  logic prev_req = 1'b0, ended = 1'b0;

  always #10 clk = ~clk;

  sdbg_port uut (
    .clk(clk), .rst_n(rst_n), .dbg_sck(dbg_sck), .dbg_sdi(dbg_sdi),
    .dbg_sdo(dbg_sdo), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  function automatic logic [15:0] seed_val(input int i);
    return 16'(i * 16'h1111) ^ 16'h5A5A;
  endfunction

  assign reg_rdata = rf[reg_idx];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin
        rf[i]      <= seed_val(i);
        mem_arr[i] <= ~seed_val(i);
      end
      mem_ack <= 1'b0; mem_rdata <= '0; wait_cnt <= 0; last_addr <= '0;
    end else begin
      if (reg_wr) rf[reg_idx] <= reg_wdata;
      if (mem_req && !mem_ack) begin
        if (wait_cnt >= mem_lat) begin
          mem_ack <= 1'b1;
          wait_cnt <= 0;
          last_addr <= mem_addr;
          if (mem_we) mem_arr[mem_addr[3:0]] <= mem_wdata;
          else        mem_rdata <= mem_arr[mem_addr[3:0]];
        end else wait_cnt <= wait_cnt + 1;
      end else mem_ack <= 1'b0;
      prev_req <= mem_req;
      if (reg_wr) wr_pulses <= wr_pulses + 1;
      if (mem_req && !prev_req) req_starts <= req_starts + 1;
      if (reg_wr && mem_req) overlap <= overlap + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // one full-duplex word, MSB first; sdo sampled just before each rising edge
  task automatic xfer(input logic [16:0] w, output logic [16:0] r);
    for (int i = 16; i >= 0; i--) begin
      dbg_sdi = w[i];
      repeat (HALF) @(negedge clk);
      r[i] = dbg_sdo;
      dbg_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      dbg_sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
  endtask

  function automatic logic [16:0] cmdw(input logic [3:0] op, input logic [3:0] idx);
    return {1'b0, op, 8'h00, idx};
  endfunction

  task automatic reg_write(input logic [3:0] idx, input logic [15:0] d, input logic hi);
    logic [16:0] r;
    xfer({hi, 4'd2, 8'h00, idx}, r);
    xfer({hi, d}, r);
    exp_rf[idx] = d;
  endtask

  task automatic reg_read_chk(input logic [3:0] idx);
    logic [16:0] r;
    xfer(cmdw(4'd1, idx), r);
    xfer(17'h0, r);
    check("R1/R4 register readback", 32'(r), {15'h0, 1'b0, exp_rf[idx]});
  endtask

  task automatic mem_op(input logic we, input logic [31:0] a, input logic [15:0] d,
                        input int lat, input logic [16:0] first_poll, output int nbusy);
    logic [16:0] r, pw;
    nbusy = 0;
    mem_lat = lat;
    xfer(cmdw(we ? 4'd4 : 4'd3, 4'h0), r);
    xfer({1'b0, a[31:16]}, r);
    check("R8 reply after memory command", 32'(r), 32'h0);
    xfer({1'b0, a[15:0]}, r);
    check("R8 reply after address word", 32'(r), 32'h0);
    if (we) begin
      xfer({1'b0, d}, r);
      check("R8 reply after address low", 32'(r), 32'h0);
    end
    pw = first_poll;
    for (int k = 0; k < 20; k++) begin
      xfer(pw, r);
      pw = 17'h0;
      if (!r[16]) break;
      nbusy++;
      check("R7 busy reply", 32'(r), 32'h10000);
    end
    if (we) begin
      exp_mem[a[3:0]] = d;
      check("R6 write completion reply", 32'(r), 32'h0);
    end else begin
      check("R6 read data reply", 32'(r), {16'h0, exp_mem[a[3:0]]});
    end
    check("R5 memory address", last_addr, a);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [16:0] r;
    int nb, w0, q0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin
      exp_rf[i] = seed_val(i);
      exp_mem[i] = ~seed_val(i);
    end
    repeat (5) @(negedge clk);
    check("R9 sdo in reset", 32'(dbg_sdo), 32'h0);
    check("R9 mem_req in reset", 32'(mem_req), 32'h0);
    check("R9 reg_wr in reset", 32'(reg_wr), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 host bit 16 ignored; R3 write then R4 read
    reg_write(4'd3, 16'hA5C3, 1'b1);
    reg_read_chk(4'd3);
    reg_read_chk(4'd9);

    for (int n = 0; n < 20; n++) begin
      logic [3:0] ix = 4'($urandom_range(0, 15));
      reg_write(ix, 16'($urandom), 1'b0);
      reg_read_chk(4'($urandom_range(0, 15)));
    end

    // zero latency: no busy reply
    mem_op(1'b1, 32'h1234_0007, 16'hBEEF, 0, 17'h0, nb);
    check("R7 zero latency write not busy", 32'(nb), 32'h0);
    mem_op(1'b0, 32'h1234_0007, 16'h0, 0, 17'h0, nb);
    check("R7 zero latency read not busy", 32'(nb), 32'h0);

    // discarded word: a real register write issued while memory is pending
    reg_write(4'd5, 16'h1234, 1'b0);
    mem_op(1'b0, 32'hCAFE_0002, 16'h0, 300, cmdw(4'd2, 4'd5), nb);
    check("R7 long latency shows busy", 32'(nb > 0), 32'h1);
    reg_read_chk(4'd5);

    for (int n = 0; n < 20; n++) begin
      logic [31:0] a = $urandom;
      mem_op(1'($urandom), a, 16'($urandom), $urandom_range(0, 400), 17'h0, nb);
    end

    // unknown opcodes and NOP do nothing
    w0 = wr_pulses; q0 = req_starts;
    xfer(17'h07ABC, r);
    xfer(17'h0F001, r);
    check("R8 reply after unknown opcode", 32'(r), 32'h0);
    xfer(17'h0, r);
    check("R8 reply after unknown opcode", 32'(r), 32'h0);
    check("R2 unknown opcode no register write", 32'(wr_pulses - w0), 32'h0);
    check("R2 unknown opcode no memory request", 32'(req_starts - q0), 32'h0);
    check("R10 no write during request", 32'(overlap), 32'h0);
    finish_run();
  end
endmodule